// File: doc/BRIEF.md
# Half-Bridge Gate Command Logic

This block sits between a motor controller and the gate drivers of one phase leg of a three-phase bridge. It takes a high-side request, a low-side request, an active-low coast input and an active-low run/shutdown input. From these it produces two registered gate enables, one for the upper switch and one for the lower switch. The two switches can never be enabled together. After any switch turns off, both switches stay off for a fixed dead time before either one may turn on. If the requested direction changes during that interval, the interval starts again.

The upper switch is also gated by its floating bootstrap supply. Two comparator levels are fed in as digital inputs: the supply is above the turn-on level, and the supply is above the turn-off level. From these the block keeps a supply-good state with hysteresis. If the supply collapses while the upper switch is on, the switch is dropped and stays locked off until its request is removed and given again. The lower switch does not depend on the bootstrap supply.

If the shutdown input is held low long enough, the block goes to sleep. The lower driver keeps actively holding its gate low for a hold-off period, and then it releases the gate. All timing counts are in clock cycles. Every asynchronous input passes through a two-stage synchronizer, so a change at an input reaches the gate enables on the third rising clock edge.

Top module: `hb_gate_ctrl`

## Requirements
- R1: While run_n is low, hs_on and ls_on are both 0. A run_n low level applied before rising edge 1 clears both outputs by rising edge 3. A low pulse on run_n shorter than SLEEP_CYC cycles leaves ls_drive at 1.
- R2: While coast_n is low, hs_on and ls_on are both 0, whatever hi_req and lo_req are. Once coast_n returns high, the requested switch turns on again.
- R3: With run_n and coast_n high, the requests decode as follows. hi_req=1 with lo_req=0 selects the upper switch. hi_req=0 with lo_req=1 selects the lower switch. 00 and 11 select neither switch. An input change shows at the outputs on the third rising edge.
- R4: hs_on and ls_on are never 1 in the same cycle.
- R5: After either output falls, both outputs stay 0 for exactly DEAD_CYC cycles before an output may rise. When the target is already settled, the opposite switch rises DEAD_CYC cycles after the fall.
- R6: If the requested direction changes while the dead time is running, the dead time starts again. It is then counted from the cycle in which the new request reaches the logic.
- R7: hs_on may rise only while the supply-good state is set. boot_above_on=1 sets that state. boot_above_off=0 clears it. With boot_above_off=1 and boot_above_on=0, the state keeps its value.
- R8: If the supply-good state clears while the upper switch is permitted, hs_on falls. It then stays 0, even after the supply recovers, until the upper request is withdrawn and given again.
- R9: The bootstrap inputs have no effect on ls_on. The lower switch still turns on with the bootstrap supply low.
- R10: Reset gives hs_on=0, ls_on=0 and ls_drive=1. If run_n stays low, ls_drive falls exactly SLEEP_CYC+HOLD_CYC cycles after the outputs were cleared. While ls_drive is 0, both enables are 0. When run_n rises, ls_drive returns to 1 in the same cycle as the gate enables respond.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hi_req | input | 1 | Upper switch request (asynchronous) |
| lo_req | input | 1 | Lower switch request (asynchronous) |
| coast_n | input | 1 | Active-low coast, forces both switches off |
| run_n | input | 1 | Active-low shutdown; a long low level enters sleep |
| boot_above_on | input | 1 | Bootstrap supply above the turn-on level |
| boot_above_off | input | 1 | Bootstrap supply above the turn-off level |
| hs_on | output | 1 | Upper gate enable |
| ls_on | output | 1 | Lower gate enable |
| ls_drive | output | 1 | Lower driver active (0 = gate released in sleep) |

## Verification
On every cycle, the assertions check four things: the two enables are never on together, the dead-time gap is respected, coast, shutdown and the 11 request code force both switches off three edges later, and a released lower driver never coincides with an enabled gate. Other behaviours depend on history, so only the bench scenarios can show them: the hysteresis of the bootstrap supply state, the lock-off after a supply drop and its release through a fresh request, the restart of the dead time when the direction changes, and the exact sleep entry count. The scoreboard also checks the cycle distance between output transitions.

// File: rtl/hb_gate_pkg.sv
package hb_gate_pkg;
  typedef enum logic [1:0] {
    SIDE_NONE = 2'd0,
    SIDE_HI   = 2'd1,
    SIDE_LO   = 2'd2
  } side_e;

  typedef enum logic [1:0] {
    PWR_RUN   = 2'd0,
    PWR_SHDN  = 2'd1,
    PWR_HOLD  = 2'd2,
    PWR_SLEEP = 2'd3
  } pwr_e;

  function automatic side_e decode_req(input logic hi, input logic lo);
    if (hi && !lo)      return SIDE_HI;
    else if (lo && !hi) return SIDE_LO;
    else                return SIDE_NONE;
  endfunction
endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= RST_VAL;
        else if (s == 0) stage_q[s] <= d;
        else stage_q[s] <= stage_q[(s > 0) ? s - 1 : 0];
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/hb_boot_qual.sv
module hb_boot_qual (
  input  logic clk,
  input  logic rst,
  input  logic above_on,
  input  logic above_off,
  input  logic hs_cmd,
  output logic hs_allow
);
  logic good_q, good_d, lock_q;

  // hysteresis: set at the upper level, clear below the lower level
  assign good_d   = above_on | (good_q & above_off);
  assign hs_allow = hs_cmd & good_q & ~lock_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      good_q <= 1'b0;
      lock_q <= 1'b0;
    end else begin
      good_q <= good_d;
      // lock survives only while the command stays asserted
      lock_q <= hs_cmd & (lock_q | (hs_allow & ~good_d));
    end
  end
endmodule

// File: rtl/hb_deadtime.sv
module hb_deadtime
  import hb_gate_pkg::*;
#(
  parameter int DEAD_CYC = 10
) (
  input  logic  clk,
  input  logic  rst,
  input  side_e want,
  output logic  hs_on,
  output logic  ls_on
);
  localparam int CW = $clog2(DEAD_CYC + 1);
  localparam logic [CW-1:0] RELOAD = CW'(DEAD_CYC - 1);

  side_e         cur_q, want_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q  <= SIDE_NONE;
      want_q <= SIDE_NONE;
      cnt_q  <= '0;
    end else begin
      want_q <= want;
      if (cur_q != SIDE_NONE) begin
        if (want != cur_q) begin
          cur_q <= SIDE_NONE;
          cnt_q <= RELOAD;
        end
      end else if (cnt_q != '0) begin
        if (want != want_q) cnt_q <= RELOAD;
        else                cnt_q <= cnt_q - 1'b1;
      end else begin
        cur_q <= want;
      end
    end
  end

  assign hs_on = (cur_q == SIDE_HI);
  assign ls_on = (cur_q == SIDE_LO);
endmodule

// File: rtl/hb_sleep_ctl.sv
module hb_sleep_ctl
  import hb_gate_pkg::*;
#(
  parameter int SLEEP_CYC = 500,
  parameter int HOLD_CYC  = 250
) (
  input  logic clk,
  input  logic rst,
  input  logic run_s,
  output logic ls_drive
);
  localparam int MAXC = (SLEEP_CYC > HOLD_CYC) ? SLEEP_CYC : HOLD_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  pwr_e          st_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= PWR_RUN;
      cnt_q <= '0;
    end else if (run_s) begin
      st_q  <= PWR_RUN;
      cnt_q <= '0;
    end else begin
      case (st_q)
        PWR_RUN: begin
          st_q  <= PWR_SHDN;
          cnt_q <= '0;
        end
        PWR_SHDN: begin
          if (cnt_q == CW'(SLEEP_CYC - 1)) begin
            st_q  <= PWR_HOLD;
            cnt_q <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        PWR_HOLD: begin
          if (cnt_q == CW'(HOLD_CYC - 1)) begin
            st_q  <= PWR_SLEEP;
            cnt_q <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        default: st_q <= PWR_SLEEP;
      endcase
    end
  end

  assign ls_drive = (st_q != PWR_SLEEP);
endmodule

// File: rtl/hb_gate_ctrl.sv
module hb_gate_ctrl
  import hb_gate_pkg::*;
#(
  parameter int DEAD_CYC    = 10,
  parameter int SLEEP_CYC   = 500,
  parameter int HOLD_CYC    = 250,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic hi_req,
  input  logic lo_req,
  input  logic coast_n,
  input  logic run_n,
  input  logic boot_above_on,
  input  logic boot_above_off,
  output logic hs_on,
  output logic ls_on,
  output logic ls_drive
);
  localparam int NIN = 6;
  // bit order: hi, lo, coast_n, run_n, above_on, above_off
  localparam logic [NIN-1:0] SYNC_RST = 6'b001100;

  logic [NIN-1:0] raw_in, syn;
  logic  enable, hs_cmd, hs_allow;
  side_e req, want;

  assign raw_in = {boot_above_off, boot_above_on, run_n, coast_n, lo_req, hi_req};

  hb_sync #(.W(NIN), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) sync_i (
    .clk(clk), .rst(rst), .d(raw_in), .q(syn)
  );

  assign enable = syn[3] & syn[2];
  assign req    = decode_req(syn[0], syn[1]);
  assign hs_cmd = enable && (req == SIDE_HI);

  hb_boot_qual boot_i (
    .clk(clk), .rst(rst), .above_on(syn[4]), .above_off(syn[5]),
    .hs_cmd(hs_cmd), .hs_allow(hs_allow)
  );

  always_comb begin
    if (hs_allow)                       want = SIDE_HI;
    else if (enable && req == SIDE_LO)  want = SIDE_LO;
    else                                want = SIDE_NONE;
  end

  hb_deadtime #(.DEAD_CYC(DEAD_CYC)) dead_i (
    .clk(clk), .rst(rst), .want(want), .hs_on(hs_on), .ls_on(ls_on)
  );

  hb_sleep_ctl #(.SLEEP_CYC(SLEEP_CYC), .HOLD_CYC(HOLD_CYC)) sleep_i (
    .clk(clk), .rst(rst), .run_s(syn[3]), .ls_drive(ls_drive)
  );
endmodule

// File: rtl/hb_gate_chk.sv
module hb_gate_chk #(
  parameter int DEAD_CYC = 10
) (
  input logic clk,
  input logic rst,
  input logic hi_req,
  input logic lo_req,
  input logic coast_n,
  input logic run_n,
  input logic hs_on,
  input logic ls_on,
  input logic ls_drive
);
  int unsigned gap_q;

  always_ff @(posedge clk) begin
    if (rst) gap_q <= DEAD_CYC;
    else if (hs_on || ls_on) gap_q <= 0;
    else if (gap_q < DEAD_CYC) gap_q <= gap_q + 1;
  end

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
    !(hs_on && ls_on)); // R4
  AST_DEAD_GAP: assert property (@(posedge clk) disable iff (rst)
    ($rose(hs_on) || $rose(ls_on)) |-> (gap_q >= DEAD_CYC)); // R5
  AST_RUN_OFF: assert property (@(posedge clk) disable iff (rst)
    !$past(run_n, 3) |-> (!hs_on && !ls_on)); // R1
  AST_COAST_OFF: assert property (@(posedge clk) disable iff (rst)
    !$past(coast_n, 3) |-> (!hs_on && !ls_on)); // R2
  AST_BOTH_REQ_OFF: assert property (@(posedge clk) disable iff (rst)
    ($past(hi_req, 3) && $past(lo_req, 3)) |-> (!hs_on && !ls_on)); // R3
  AST_RELEASED_OFF: assert property (@(posedge clk) disable iff (rst)
    !ls_drive |-> (!hs_on && !ls_on)); // R10
endmodule

bind hb_gate_ctrl hb_gate_chk #(.DEAD_CYC(DEAD_CYC)) chk_i (
  .clk(clk), .rst(rst), .hi_req(hi_req), .lo_req(lo_req),
  .coast_n(coast_n), .run_n(run_n), .hs_on(hs_on), .ls_on(ls_on),
  .ls_drive(ls_drive)
);

// File: tb/hb_gate_ctrl_tb_top.sv
module hb_gate_ctrl_tb_top;
  localparam int DT  = 10;
  localparam int SLP = 500;
  localparam int HLD = 250;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst = 1'b1;
  logic hi_req = 1'b0, lo_req = 1'b0, coast_n = 1'b1, run_n = 1'b1;
  logic boot_above_on = 1'b1, boot_above_off = 1'b1;
  logic hs_on, ls_on, ls_drive;

  hb_gate_ctrl #(.DEAD_CYC(DT), .SLEEP_CYC(SLP), .HOLD_CYC(HLD)) dut_i (
    .clk(clk), .rst(rst), .hi_req(hi_req), .lo_req(lo_req),
    .coast_n(coast_n), .run_n(run_n), .boot_above_on(boot_above_on),
    .boot_above_off(boot_above_off), .hs_on(hs_on), .ls_on(ls_on),
    .ls_drive(ls_drive)
  );

  // vector {hs_on, ls_on, ls_drive}
  localparam logic [2:0] V_OFF = 3'b001, V_HS = 3'b101, V_LS = 3'b011, V_REL = 3'b000;

  int checks = 0, errors = 0;
  int cyc = 0, last_cyc = 0;
  logic [2:0] exp_v_q[$];
  int         exp_d_q[$];
  string      exp_t_q[$];
  logic [2:0] prev_v = V_OFF;
  bit done = 0;
  wire [2:0] out_v = {hs_on, ls_on, ls_drive};

  task automatic push(input logic [2:0] v, input int d, input string t);
    exp_v_q.push_back(v);
    exp_d_q.push_back(d);
    exp_t_q.push_back(t);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic quiet(input logic [2:0] v, input string t);
    checks++;
    if (exp_v_q.size() != 0 || out_v !== v) begin
      errors++;
      $display("FAIL %s: outputs %b with %0d pending, expected %b with 0 pending",
               t, out_v, exp_v_q.size(), v);
      exp_v_q.delete(); exp_d_q.delete(); exp_t_q.delete();
    end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // monitor: pops one expected transition per observed output change
  always @(negedge clk) begin
    cyc++;
    if (rst) begin
      prev_v   = out_v;
      last_cyc = cyc;
    end else if (out_v !== prev_v) begin
      checks++;
      if (exp_v_q.size() == 0) begin
        errors++;
        $display("FAIL unexpected change: outputs %b, expected %b", out_v, prev_v);
      end else begin
        logic [2:0] ev;
        int ed;
        string et;
        ev = exp_v_q.pop_front();
        ed = exp_d_q.pop_front();
        et = exp_t_q.pop_front();
        if (out_v !== ev || (ed >= 0 && (cyc - last_cyc) != ed)) begin
          errors++;
          $display("FAIL %s: outputs %b after %0d cycles, expected %b after %0d",
                   et, out_v, cyc - last_cyc, ev, ed);
        end
      end
      last_cyc = cyc;
      prev_v   = out_v;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run not finished, expected finish");
    finish_run();
  end

  initial begin
    step(5);
    rst = 1'b0;
    step(10);
    quiet(V_OFF, "R10 reset state");

    // R3: low side alone
    lo_req = 1'b1; push(V_LS, -1, "R3 low request");
    step(20); quiet(V_LS, "R3 low steady");

    // R5: low to high direction change
    lo_req = 1'b0; hi_req = 1'b1;
    push(V_OFF, -1, "R5 low off"); push(V_HS, DT, "R5 high after dead time");
    step(30); quiet(V_HS, "R5 high steady");

    // R5: high to low
    hi_req = 1'b0; lo_req = 1'b1;
    push(V_OFF, -1, "R5 high off"); push(V_LS, DT, "R5 low after dead time");
    step(30); quiet(V_LS, "R5 low steady");

    // R3: both requests select neither switch
    hi_req = 1'b1; push(V_OFF, -1, "R3 both requests");
    step(30); quiet(V_OFF, "R3 both steady off");
    hi_req = 1'b0; push(V_LS, -1, "R3 low again");
    step(30); quiet(V_LS, "R3 low restored");

    // R6: direction flips during dead time, restart counted from the flip
    lo_req = 1'b0; hi_req = 1'b1; push(V_OFF, -1, "R6 low off");
    step(4);
    hi_req = 1'b0; lo_req = 1'b1; push(V_LS, 4 + DT, "R6 restarted dead time");
    step(40); quiet(V_LS, "R6 settled");

    // R2: coast overrides requests
    coast_n = 1'b0; push(V_OFF, -1, "R2 coast off");
    step(10);
    lo_req = 1'b0; hi_req = 1'b1;
    step(20); quiet(V_OFF, "R2 requests ignored in coast");
    hi_req = 1'b0; lo_req = 1'b1;
    step(5);
    coast_n = 1'b1; push(V_LS, -1, "R2 coast released");
    step(30); quiet(V_LS, "R2 after coast");

    // R7: supply-good hysteresis
    lo_req = 1'b0; push(V_OFF, -1, "R7 low off");
    boot_above_on = 1'b0; boot_above_off = 1'b0;
    step(20);
    boot_above_off = 1'b1;
    step(5);
    hi_req = 1'b1;
    step(30); quiet(V_OFF, "R7 high blocked between levels");
    boot_above_on = 1'b1; push(V_HS, -1, "R7 high after turn-on level");
    step(30);
    boot_above_on = 1'b0;
    step(30); quiet(V_HS, "R7 high kept between levels");

    // R8: supply drop locks the high side off
    boot_above_off = 1'b0; push(V_OFF, -1, "R8 high dropped");
    step(20);
    boot_above_on = 1'b1; boot_above_off = 1'b1;
    step(30); quiet(V_OFF, "R8 locked after recovery");
    hi_req = 1'b0;
    step(20); quiet(V_OFF, "R8 request withdrawn");
    hi_req = 1'b1; push(V_HS, -1, "R8 fresh request");
    step(30); quiet(V_HS, "R8 high restored");

    // R9: low side ignores the bootstrap supply
    hi_req = 1'b0; push(V_OFF, -1, "R9 high off");
    boot_above_on = 1'b0; boot_above_off = 1'b0;
    step(20);
    lo_req = 1'b1; push(V_LS, -1, "R9 low with supply low");
    step(30); quiet(V_LS, "R9 low steady");
    boot_above_on = 1'b1; boot_above_off = 1'b1;
    step(10);

    // R1: short shutdown pulse, no sleep
    run_n = 1'b0; push(V_OFF, -1, "R1 shutdown off");
    step(20); quiet(V_OFF, "R1 short pulse keeps driver");
    run_n = 1'b1; push(V_LS, -1, "R1 run restored");
    step(30); quiet(V_LS, "R1 after pulse");

    // R10: long shutdown enters sleep after hold-off
    run_n = 1'b0;
    push(V_OFF, -1, "R10 outputs off");
    push(V_REL, SLP + HLD, "R10 driver released");
    step(SLP + HLD + 50); quiet(V_REL, "R10 asleep");
    run_n = 1'b1; push(V_LS, -1, "R10 wake");
    step(30); quiet(V_LS, "R10 awake");

    finish_run();
  end
endmodule